// File: doc/BRIEF.md
# Register Update Unit

This block is an eight-entry circular buffer. It tracks instructions in flight between decode and retirement, and it serves as both the reservation station and the reorder buffer. The decoder hands it at most one instruction per clock. Each instruction carries a destination register and two source operands. A source operand is either a value that is ready to use, or the tag of the older entry that will produce it. The entry allocated to the instruction is identified by its index, and that index is the instruction's tag.

While an instruction waits, its missing operands are filled by snooping up to two result buses. Each bus carries a valid bit, a producer tag and a data word. Once both operands of an entry are present, it competes to issue. An instruction is sent to the functional unit only when that unit is free and a result-bus slot has been reserved for its result; the oldest candidate wins. When the result comes back on a bus, it is written into the producing entry, and that entry becomes complete. Retirement looks only at the oldest entry. When that entry is complete, its destination register and value are presented on the commit port for the architectural register file, and the entry is released. Instructions therefore retire in program order even though they execute out of order.

Top module: `reg_update_unit`

## Requirements
- R1: An accepted dispatch occupies the entry at the allocation pointer, and `disp_tag` shows that index. Tags start at 0 after reset and increase by one per accepted dispatch, wrapping from 7 back to 0.
- R2: A dispatched source whose ready flag is 1 holds the value supplied with it. A source whose ready flag is 0 waits on the supplied producer tag.
- R3: When a result bus has its valid bit set and its tag equals a waiting source's tag, the source takes that bus's data. The source is ready from the next cycle, and it issues with that data. Each bus is matched independently.
- R4: A source dispatched as waiting on a tag that is being broadcast in the same cycle takes the broadcast data. It does not stay waiting.
- R5: A broadcast whose tag names an occupied entry stores the data as that entry's result and marks the entry complete. The committed value is that data.
- R6: `iss_valid` is 1 only when some entry holds two ready operands and has not issued yet, and `fu_free` and `slot_grant` are both 1. An entry issues once.
- R7: When several entries qualify, the one issued is the oldest, counted from the retirement pointer. `iss_tag`, `iss_dst`, `iss_a` and `iss_b` describe that entry.
- R8: `cmt_valid` is 1 exactly when the oldest entry is complete. The oldest entry then leaves in that cycle with its destination and result. A complete younger entry never retires ahead of it.
- R9: `full` is 1 while all eight entries are occupied. A dispatch offered while `full` is 1 is ignored, and the next tag is not consumed.
- R10: A dispatch and a retirement in the same cycle both take effect, and the occupancy stays unchanged.
- R11: After reset the buffer is empty: `full`, `iss_valid` and `cmt_valid` are 0 and `disp_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | REG_W | Destination register of the dispatched instruction |
| disp_a_ready | input | 1 | Source A value is supplied |
| disp_a_tag | input | TAG_W | Producer tag of source A when it is not ready |
| disp_a_value | input | DATA_W | Value of source A when it is ready |
| disp_b_ready | input | 1 | Source B value is supplied |
| disp_b_tag | input | TAG_W | Producer tag of source B when it is not ready |
| disp_b_value | input | DATA_W | Value of source B when it is ready |
| disp_tag | output | TAG_W | Tag given to the instruction offered this cycle |
| full | output | 1 | All entries are occupied |
| fu_free | input | 1 | The functional unit can accept an instruction |
| slot_grant | input | 1 | A result-bus slot is reserved for this cycle's issue |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tag | output | TAG_W | Tag of the issued entry |
| iss_dst | output | REG_W | Destination register of the issued entry |
| iss_a | output | DATA_W | Operand A of the issued entry |
| iss_b | output | DATA_W | Operand B of the issued entry |
| res_valid | input | NUM_BUS | Per-bus broadcast valid |
| res_tag | input | NUM_BUS x TAG_W | Per-bus producer tag |
| res_data | input | NUM_BUS x DATA_W | Per-bus result data |
| cmt_valid | output | 1 | The oldest entry retires this cycle |
| cmt_dst | output | REG_W | Destination register being retired |
| cmt_data | output | DATA_W | Value written to the register file |

## Verification
The hardest case to reach is a consumer that arrives at dispatch in the exact cycle its producer's result is on a bus. The outcome depends on one edge, so the stimulus has to line up a broadcast and a dispatch in the same cycle. To get there, the bench decides the bus traffic for a cycle first. It then often draws a source's producer tag from a bus that is active in that same cycle. A phase that keeps dispatch requests continuous and blocks issue fills the buffer and offers dispatches while it is full. A later phase with dense dispatch keeps the buffer near capacity, so that allocation and retirement coincide.

// File: rtl/ruu_pkg.sv
// Package ruu_pkg
// Purpose: default sizes shared by the register update unit and its sub-blocks.
// Assumes: the depth is a power of two, because tags are plain entry indices.
package ruu_pkg;
    localparam int RUU_DEPTH_DEF = 8;
    localparam int RUU_BUS_DEF   = 2;
    localparam int RUU_DATA_DEF  = 16;
    localparam int RUU_REG_DEF   = 5;
endpackage

// File: rtl/ruu_tag_match.sv
// Module ruu_tag_match
// Purpose: compares one tag against every result bus and returns the data
//          of the bus that matches. This is one comparator set per bus.
// Assumes: at most one bus carries a given tag in a cycle; if two do, the
//          lower-numbered bus wins.
module ruu_tag_match #(
    parameter int NUM_BUS = 2,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 16
) (
    input  logic [NUM_BUS-1:0]             bus_valid,
    input  logic [NUM_BUS-1:0][TAG_W-1:0]  bus_tag,
    input  logic [NUM_BUS-1:0][DATA_W-1:0] bus_data,
    input  logic [TAG_W-1:0]               want_tag,
    output logic                           hit,
    output logic [DATA_W-1:0]              hit_data
);
    // Scan the buses from the highest index down so that the lowest matching bus has the final say.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (bus_valid[b] && (bus_tag[b] == want_tag)) begin
                hit      = 1'b1;
                hit_data = bus_data[b];
            end
        end
    end
endmodule

// File: rtl/ruu_oldest_pick.sv
// Module ruu_oldest_pick
// Purpose: returns the first set request, searching from the head index
//          upward with wrap-around; this is the oldest candidate.
// Assumes: DEPTH == 2**TAG_W, so adding to the index wraps on its own.
module ruu_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input  logic [DEPTH-1:0] req,
    input  logic [TAG_W-1:0] head,
    output logic             found,
    output logic [TAG_W-1:0] idx
);
    logic [TAG_W-1:0] cand;

    // Walk the ring in age order and keep the first request seen.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = head;
        for (int k = 0; k < DEPTH; k++) begin
            cand = head + TAG_W'(k);
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end
endmodule

// File: rtl/ruu_ring_ptrs.sv
// Module ruu_ring_ptrs
// Purpose: keeps the allocation (tail) and retirement (head) pointers of the
//          ring and its occupancy, and reports when the ring is full.
// Assumes: the caller never pushes while full and never pops while empty.
module ruu_ring_ptrs #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full
);
    localparam int CNT_W = TAG_W + 1;

    logic [CNT_W-1:0] count;

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + 1'b1;
            if (pop)  head <= head + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Full flag decoded from the occupancy count.
    always_comb full = (count == CNT_W'(DEPTH));

    // R8: each retirement moves the head forward by exactly one entry.
    assert_head_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> head == TAG_W'($past(head) + 1'b1));

    // R9: a full ring has its two pointers meeting.
    assert_full_ptrs_meet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> head == tail);

    // R10: an allocation and a retirement together leave the occupancy unchanged.
    assert_count_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> count == $past(count));

    // R1: an allocation alone adds one occupied entry.
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/reg_update_unit.sv
// Module reg_update_unit
// Purpose: a ring of entries. Each entry holds one in-flight instruction
//          from dispatch to retirement: it waits for its operands by
//          matching tags on the result buses, issues when it is oldest-ready
//          and the unit and a bus slot are free, captures its own result,
//          and retires in order from the head.
// Assumes: DEPTH is a power of two; the dispatcher only names producer tags
//          of occupied entries that have not completed yet; result tags come
//          from issued entries.
module reg_update_unit
    import ruu_pkg::*;
#(
    parameter int DEPTH   = RUU_DEPTH_DEF,
    parameter int NUM_BUS = RUU_BUS_DEF,
    parameter int DATA_W  = RUU_DATA_DEF,
    parameter int REG_W   = RUU_REG_DEF,
    parameter int TAG_W   = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           disp_valid,
    input  logic [REG_W-1:0]               disp_dst,
    input  logic                           disp_a_ready,
    input  logic [TAG_W-1:0]               disp_a_tag,
    input  logic [DATA_W-1:0]              disp_a_value,
    input  logic                           disp_b_ready,
    input  logic [TAG_W-1:0]               disp_b_tag,
    input  logic [DATA_W-1:0]              disp_b_value,
    output logic [TAG_W-1:0]               disp_tag,
    output logic                           full,
    input  logic                           fu_free,
    input  logic                           slot_grant,
    output logic                           iss_valid,
    output logic [TAG_W-1:0]               iss_tag,
    output logic [REG_W-1:0]               iss_dst,
    output logic [DATA_W-1:0]              iss_a,
    output logic [DATA_W-1:0]              iss_b,
    input  logic [NUM_BUS-1:0]             res_valid,
    input  logic [NUM_BUS-1:0][TAG_W-1:0]  res_tag,
    input  logic [NUM_BUS-1:0][DATA_W-1:0] res_data,
    output logic                           cmt_valid,
    output logic [REG_W-1:0]               cmt_dst,
    output logic [DATA_W-1:0]              cmt_data
);
    logic [TAG_W-1:0]  head, tail, pick_idx;
    logic              disp_fire, cmt_fire, pick_found;
    logic [DEPTH-1:0]  ent_valid, ent_issued, ent_exec, a_rdy, b_rdy, ready_vec;
    logic [DEPTH-1:0]  wake_a, wake_b, own_hit;
    logic [TAG_W-1:0]  a_tag   [DEPTH];
    logic [TAG_W-1:0]  b_tag   [DEPTH];
    logic [DATA_W-1:0] a_val   [DEPTH];
    logic [DATA_W-1:0] b_val   [DEPTH];
    logic [DATA_W-1:0] dst_val [DEPTH];
    logic [REG_W-1:0]  dst_reg [DEPTH];
    logic [DATA_W-1:0] wake_a_data [DEPTH];
    logic [DATA_W-1:0] wake_b_data [DEPTH];
    logic [DATA_W-1:0] own_data    [DEPTH];
    logic              dsp_a_hit, dsp_b_hit;
    logic [DATA_W-1:0] dsp_a_data, dsp_b_data;

    ruu_ring_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (disp_fire),
        .pop   (cmt_fire),
        .head  (head),
        .tail  (tail),
        .full  (full)
    );

    // Per-entry comparators: one set for each source and one for the entry's own result.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        ruu_tag_match #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_a (
            .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
            .want_tag  (a_tag[gi]), .hit (wake_a[gi]), .hit_data (wake_a_data[gi])
        );
        ruu_tag_match #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_b (
            .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
            .want_tag  (b_tag[gi]), .hit (wake_b[gi]), .hit_data (wake_b_data[gi])
        );
        ruu_tag_match #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_own (
            .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
            .want_tag  (TAG_W'(gi)), .hit (own_hit[gi]), .hit_data (own_data[gi])
        );

        // R3: a waiting source that sees its producer on a bus is ready one cycle later.
        assert_wakeup_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ent_valid[gi] && !a_rdy[gi] && wake_a[gi] && !(cmt_fire && head == TAG_W'(gi))
            |=> a_rdy[gi]);
        assert_wakeup_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ent_valid[gi] && !b_rdy[gi] && wake_b[gi] && !(cmt_fire && head == TAG_W'(gi))
            |=> b_rdy[gi]);
    end

    // Comparators for the two sources arriving at dispatch (same-cycle wakeup).
    ruu_tag_match #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dsp_a (
        .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
        .want_tag  (disp_a_tag), .hit (dsp_a_hit), .hit_data (dsp_a_data)
    );
    ruu_tag_match #(.NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dsp_b (
        .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
        .want_tag  (disp_b_tag), .hit (dsp_b_hit), .hit_data (dsp_b_data)
    );

    // Issue candidates: occupied, not yet issued, both operands present.
    always_comb ready_vec = ent_valid & ~ent_issued & a_rdy & b_rdy;

    ruu_oldest_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
        .req   (ready_vec),
        .head  (head),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Handshake decisions and the issue and commit port contents.
    always_comb begin
        disp_fire = disp_valid & ~full;
        disp_tag  = tail;
        iss_valid = pick_found & fu_free & slot_grant;
        iss_tag   = pick_idx;
        iss_dst   = dst_reg[pick_idx];
        iss_a     = a_val[pick_idx];
        iss_b     = b_val[pick_idx];
        cmt_valid = ent_valid[head] & ent_exec[head];
        cmt_fire  = cmt_valid;
        cmt_dst   = dst_reg[head];
        cmt_data  = dst_val[head];
    end

    // Entry state: allocate, wake sources, mark issue, capture result, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_issued <= '0;
            ent_exec   <= '0;
            a_rdy      <= '0;
            b_rdy      <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmt_fire && head == TAG_W'(i)) ent_valid[i] <= 1'b0;
                if (disp_fire && tail == TAG_W'(i)) begin
                    ent_valid[i]  <= 1'b1;
                    ent_issued[i] <= 1'b0;
                    ent_exec[i]   <= 1'b0;
                    dst_reg[i]    <= disp_dst;
                    dst_val[i]    <= '0;
                    a_tag[i]      <= disp_a_tag;
                    b_tag[i]      <= disp_b_tag;
                    a_rdy[i]      <= disp_a_ready | dsp_a_hit;
                    b_rdy[i]      <= disp_b_ready | dsp_b_hit;
                    a_val[i]      <= disp_a_ready ? disp_a_value : dsp_a_data;
                    b_val[i]      <= disp_b_ready ? disp_b_value : dsp_b_data;
                end else if (ent_valid[i]) begin
                    if (!a_rdy[i] && wake_a[i]) begin
                        a_rdy[i] <= 1'b1;
                        a_val[i] <= wake_a_data[i];
                    end
                    if (!b_rdy[i] && wake_b[i]) begin
                        b_rdy[i] <= 1'b1;
                        b_val[i] <= wake_b_data[i];
                    end
                    if (iss_valid && pick_idx == TAG_W'(i)) ent_issued[i] <= 1'b1;
                    if (own_hit[i]) begin
                        ent_exec[i] <= 1'b1;
                        dst_val[i]  <= own_data[i];
                    end
                end
            end
        end
    end

    // R1: the announced tag is occupied right after an accepted dispatch.
    assert_alloc_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |=> ent_valid[$past(disp_tag)]);

    // R6: an issued entry is occupied, has both operands and has not issued before.
    assert_issue_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ent_valid[iss_tag] && a_rdy[iss_tag] && b_rdy[iss_tag] && !ent_issued[iss_tag]);

    // R6: after issuing, the entry cannot be offered again.
    assert_issue_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> ent_issued[$past(iss_tag)]);

    // R5: every broadcast that names an occupied entry completes that entry.
    for (genvar gb = 0; gb < NUM_BUS; gb++) begin : g_bus_chk
        assert_result_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid[gb] && ent_valid[res_tag[gb]] |=> ent_exec[$past(res_tag[gb])]);
    end
endmodule

// File: tb/test_reg_update_unit.sv
module test_reg_update_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int NB = 2;
    localparam int TW = 3;
    localparam int DW = 16;
    localparam int RW = 5;
    localparam int NREG = 1 << RW;
    localparam int MAX_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic                   disp_valid, disp_a_ready, disp_b_ready;
    logic [RW-1:0]          disp_dst;
    logic [TW-1:0]          disp_a_tag, disp_b_tag, disp_tag, iss_tag;
    logic [DW-1:0]          disp_a_value, disp_b_value, iss_a, iss_b, cmt_data;
    logic                   full, fu_free, slot_grant, iss_valid, cmt_valid;
    logic [RW-1:0]          iss_dst, cmt_dst;
    logic [NB-1:0]          res_valid;
    logic [NB-1:0][TW-1:0]  res_tag;
    logic [NB-1:0][DW-1:0]  res_data;

    reg_update_unit #(.DEPTH(N), .NUM_BUS(NB), .DATA_W(DW), .REG_W(RW)) i_reg_update_unit (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_a_ready(disp_a_ready), .disp_a_tag(disp_a_tag), .disp_a_value(disp_a_value),
        .disp_b_ready(disp_b_ready), .disp_b_tag(disp_b_tag), .disp_b_value(disp_b_value),
        .disp_tag(disp_tag), .full(full), .fu_free(fu_free), .slot_grant(slot_grant),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data)
    );

    // Reference model: program-ordered queue of in-flight instructions.
    typedef struct {
        int          tag;
        int          dst;
        bit          ar;
        int          at;
        logic [DW-1:0] av;
        int          ao;
        bit          br;
        int          bt;
        logic [DW-1:0] bv;
        int          bo;
        bit          iss;
        bit          exe;
        logic [DW-1:0] res;
    } ment_t;

    ment_t         mq[$];
    int            pend_tag[$];
    logic [DW-1:0] pend_val[$];
    logic [DW-1:0] arch_dut [NREG];
    logic [DW-1:0] arch_ref [NREG];
    int checks = 0;
    int fails = 0;
    int next_tag = 0;
    int disp_mode = 0;
    int fu_pct = 70;
    int cyc = 0;
    bit last_both = 0;
    bit done = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string org(int code);
        if (code == 4) return "R4";
        if (code == 3) return "R3";
        return "R2";
    endfunction

    function automatic logic [DW-1:0] rfun(logic [DW-1:0] a, logic [DW-1:0] b, int t);
        return a + (b ^ 16'h5a5a) + DW'(t);
    endfunction

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Choose a source: a supplied value, an older unfinished producer, or a producer on a bus now.
    task automatic pick_src(output logic rdy, output logic [TW-1:0] tg, output logic [DW-1:0] val);
        int r;
        int cand[$];
        r   = int'($urandom % 4);
        rdy = 1'b1;
        tg  = TW'($urandom);
        val = DW'($urandom);
        if (r == 2) begin
            for (int k = 0; k < mq.size(); k++) if (!mq[k].exe) cand.push_back(mq[k].tag);
        end else if (r == 3) begin
            for (int b = 0; b < NB; b++) if (res_valid[b]) cand.push_back(int'(res_tag[b]));
        end
        if (cand.size() > 0) begin
            rdy = 1'b0;
            tg  = TW'(cand[$urandom % cand.size()]);
        end
    endtask

    task automatic step();
        int pick;
        bit exp_full, exp_cmt, exp_iss, dfire;
        logic [RW-1:0] seen_dst;
        logic [DW-1:0] seen_data;
        bit seen_cmt;
        ment_t e;
        @(negedge clk);
        res_valid = '0;
        res_tag   = '0;
        res_data  = '0;
        for (int b = 0; b < NB; b++) begin
            if (pend_tag.size() > 0 && ($urandom % 3) != 0) begin
                int k = int'($urandom % pend_tag.size());
                res_valid[b] = 1'b1;
                res_tag[b]   = TW'(pend_tag[k]);
                res_data[b]  = pend_val[k];
                pend_tag.delete(k);
                pend_val.delete(k);
            end
        end
        fu_free    = int'($urandom % 100) < fu_pct;
        slot_grant = int'($urandom % 100) < fu_pct;
        disp_valid = (disp_mode == 1) ? 1'b1 : (disp_mode == 2) ? 1'b0 : (int'($urandom % 100) < 60);
        disp_dst   = RW'($urandom);
        pick_src(disp_a_ready, disp_a_tag, disp_a_value);
        pick_src(disp_b_ready, disp_b_tag, disp_b_value);
        #1;
        exp_full = (mq.size() == N);
        exp_cmt  = (mq.size() > 0) && mq[0].exe;
        pick = -1;
        for (int k = 0; k < mq.size(); k++)
            if (pick < 0 && !mq[k].iss && mq[k].ar && mq[k].br) pick = k;
        exp_iss = (pick >= 0) && fu_free && slot_grant;
        chk(last_both ? "R10" : "R9", "full", full, exp_full);
        chk("R1", "disp_tag", disp_tag, next_tag % N);
        chk("R6", "iss_valid", iss_valid, exp_iss);
        if (exp_iss && iss_valid) begin
            chk("R7", "iss_tag", iss_tag, mq[pick].tag);
            chk("R7", "iss_dst", iss_dst, mq[pick].dst);
            chk(org(mq[pick].ao), "iss_a", iss_a, mq[pick].av);
            chk(org(mq[pick].bo), "iss_b", iss_b, mq[pick].bv);
        end
        chk("R8", "cmt_valid", cmt_valid, exp_cmt);
        if (exp_cmt && cmt_valid) begin
            chk("R8", "cmt_dst", cmt_dst, mq[0].dst);
            chk("R5", "cmt_data", cmt_data, mq[0].res);
        end
        seen_cmt  = cmt_valid;
        seen_dst  = cmt_dst;
        seen_data = cmt_data;
        dfire = disp_valid && !exp_full;
        @(posedge clk);
        if (seen_cmt) arch_dut[seen_dst] = seen_data;
        if (exp_iss) begin
            e = mq[pick];
            e.iss = 1;
            mq[pick] = e;
            pend_tag.push_back(e.tag);
            pend_val.push_back(rfun(e.av, e.bv, e.tag));
        end
        if (exp_cmt) begin
            arch_ref[mq[0].dst] = mq[0].res;
            void'(mq.pop_front());
        end
        for (int k = 0; k < mq.size(); k++) begin
            e = mq[k];
            for (int b = 0; b < NB; b++) begin
                if (res_valid[b]) begin
                    if (!e.ar && e.at == int'(res_tag[b])) begin e.ar = 1; e.av = res_data[b]; e.ao = 3; end
                    if (!e.br && e.bt == int'(res_tag[b])) begin e.br = 1; e.bv = res_data[b]; e.bo = 3; end
                    if (e.tag == int'(res_tag[b])) begin e.exe = 1; e.res = res_data[b]; end
                end
            end
            mq[k] = e;
        end
        if (dfire) begin
            e = '{default: 0};
            e.tag = next_tag % N;
            e.dst = int'(disp_dst);
            e.ar = disp_a_ready; e.at = int'(disp_a_tag); e.av = disp_a_value; e.ao = 2;
            e.br = disp_b_ready; e.bt = int'(disp_b_tag); e.bv = disp_b_value; e.bo = 2;
            for (int b = 0; b < NB; b++) begin
                if (res_valid[b] && !e.ar && e.at == int'(res_tag[b])) begin e.ar = 1; e.av = res_data[b]; e.ao = 4; end
                if (res_valid[b] && !e.br && e.bt == int'(res_tag[b])) begin e.br = 1; e.bv = res_data[b]; e.bo = 4; end
            end
            mq.push_back(e);
            next_tag++;
        end
        last_both = dfire && exp_cmt;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYCLES && !done) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            finish_run();
        end
    end

    initial begin
        disp_valid = 0; disp_dst = '0;
        disp_a_ready = 0; disp_a_tag = '0; disp_a_value = '0;
        disp_b_ready = 0; disp_b_tag = '0; disp_b_value = '0;
        fu_free = 0; slot_grant = 0;
        res_valid = '0; res_tag = '0; res_data = '0;
        for (int r = 0; r < NREG; r++) begin arch_dut[r] = '0; arch_ref[r] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: empty state out of reset.
        chk("R11", "full after reset", full, 0);
        chk("R11", "iss_valid after reset", iss_valid, 0);
        chk("R11", "cmt_valid after reset", cmt_valid, 0);
        chk("R11", "disp_tag after reset", disp_tag, 0);
        rst_n = 1'b1;
        // Fill with issue blocked: reaches full, then offers dispatches while full (R9).
        disp_mode = 1; fu_pct = 0;
        repeat (12) step();
        // Let everything issue and drain.
        disp_mode = 2; fu_pct = 100;
        repeat (40) step();
        // Mixed traffic.
        disp_mode = 0; fu_pct = 70;
        repeat (4000) step();
        // Dense dispatch keeps the ring near full so allocation meets retirement (R10).
        disp_mode = 1; fu_pct = 50;
        repeat (1000) step();
        // Drain.
        disp_mode = 2; fu_pct = 100;
        for (int g = 0; g < 500 && (mq.size() > 0 || pend_tag.size() > 0); g++) step();
        chk("R8", "model drained", mq.size(), 0);
        for (int r = 0; r < NREG; r++) chk("R8", "register file", arch_dut[r], arch_ref[r]);
        finish_run();
    end
endmodule